// File: doc/BRIEF.md
# Dual-Bank Prioritised Interrupt Controller

This block collects up to 32 interrupt inputs and presents them to a processor as two independent request lines: a normal request bank and a fast request bank. Each input first passes through a per-source polarity stage. It then goes through a per-source capture stage that either follows the input level or latches a rising edge until software clears it. Each bank holds its own enable mask, its own priority threshold and its own set of edge latches. It picks the single most urgent eligible source and reports that source's number.

Software reaches everything through a simple word-addressed register port. A write takes effect on the clock edge where it is presented. A read returns data on the clock edge after the request. Reading a bank's acknowledge word clears that bank's edge latches as a side effect. The usual service loop reads the bank status, then reads the current source, handles it, and repeats until the status reads zero.

Top module: `irqc_dual_bank`

## Requirements
- R1: After reset both request outputs are low, both enable masks read 0, both thresholds read 0xF, the invert-select word (0x200) reads all ones, the sticky-select word (0x204) reads 0 and every priority reads 0.
- R2: In a bank (normal bank at base 0x000, fast bank at base 0x100), writing to +0x08 sets the enable bits where the data has a 1, and writing to +0x0C clears them. Reading +0x08 returns the mask.
- R3: A source whose sticky-select bit is 0 is pending exactly while its adjusted input is high. The request output follows it combinationally, in the same cycle.
- R4: A 1 in invert-select bit i passes input i unchanged. A 0 makes the source active while its input is low.
- R5: A source whose sticky-select bit is 1 becomes pending in a bank on the clock edge after a rising edge of its adjusted input. It stays pending after the input falls until that bank's acknowledge word (+0x28) is read. A read of the other bank's acknowledge word leaves it pending.
- R6: Priorities are 4-bit values at 0x300 + 4*i, where 0 is the most urgent. Among eligible sources the lowest value wins, and on a tie the lowest index wins. The winner's index is driven on the bank's id output and is returned by reading +0x20. Both read 0 when nothing is eligible.
- R7: A source is eligible in a bank only when it is pending, enabled and its priority is less than or equal to the bank threshold at +0x2C. A threshold of 0xF accepts every priority.
- R8: Bank status (+0x00) reads the eligible-source bitmap, which is nonzero exactly when the request output is high. Raw status (+0x04) reads the pending bitmap regardless of enable or threshold.
- R9: The two banks decide independently. A source enabled in both banks is reported by both, each under its own threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Interrupt source inputs |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | AW | Byte address of the register word |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Normal bank request |
| irq_id_o | output | $clog2(NSRC) | Normal bank selected source |
| fiq_o | output | 1 | Fast bank request |
| fiq_id_o | output | $clog2(NSRC) | Fast bank selected source |

## Verification
Level sources reach the request and id outputs in the same cycle. The bench therefore drives inputs on a falling edge and samples a moment later, before any rising edge. A sticky edge takes effect only after the next rising edge, so those checks sample at the following falling edge. Register reads return data on the edge after the strobe, and the bench reads them at the falling edge that follows. The acknowledge side effect is visible to the request outputs right after that same edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // word offsets inside one bank
   localparam logic [7:0] OFS_STATUS = 8'h00;
   localparam logic [7:0] OFS_RAW    = 8'h04;
   localparam logic [7:0] OFS_ENSET  = 8'h08;
   localparam logic [7:0] OFS_ENCLR  = 8'h0C;
   localparam logic [7:0] OFS_CUR    = 8'h20;
   localparam logic [7:0] OFS_ACK    = 8'h28;
   localparam logic [7:0] OFS_THR    = 8'h2C;
   // global words
   localparam logic [7:0] OFS_INVERT = 8'h00;
   localparam logic [7:0] OFS_STICKY = 8'h04;
   // address regions selected by addr[9:8]
   localparam logic [1:0] RGN_IRQ  = 2'd0;
   localparam logic [1:0] RGN_FIQ  = 2'd1;
   localparam logic [1:0] RGN_GLB  = 2'd2;
   localparam logic [1:0] RGN_PRIO = 2'd3;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] lvl_i,
   input  logic [NSRC-1:0] rise_i,
   input  logic [NSRC-1:0] sticky_i,
   input  logic            ack_i,
   output logic [NSRC-1:0] pend_o
);
   logic [NSRC-1:0] latch_q;

   // a new edge wins over a simultaneous acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= (latch_q & ~{NSRC{ack_i}}) | (rise_i & sticky_i);
   end

   assign pend_o = (sticky_i & latch_q) | (~sticky_i & lvl_i);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 4,
   localparam int IDW   = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]        elig_i,
   input  logic [NSRC*PRIO_W-1:0] prio_i,
   output logic                   valid_o,
   output logic [IDW-1:0]         id_o
);
   logic [PRIO_W-1:0] best;

   // scan from the top index down; "<=" lets a lower index take a tie
   always_comb begin
      valid_o = 1'b0;
      id_o    = '0;
      best    = '1;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (elig_i[i] && (prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
            best    = prio_i[i*PRIO_W +: PRIO_W];
            id_o    = IDW'(i);
            valid_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
   import irqc_pkg::*;
#(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 4,
   parameter int DW     = 32,
   localparam int IDW   = $clog2(NSRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sel_i,
   input  logic                   wr_i,
   input  logic                   rd_i,
   input  logic [7:0]             ofs_i,
   input  logic [DW-1:0]          wdata_i,
   input  logic [NSRC-1:0]        lvl_i,
   input  logic [NSRC-1:0]        rise_i,
   input  logic [NSRC-1:0]        sticky_i,
   input  logic [NSRC*PRIO_W-1:0] prio_i,
   output logic [NSRC-1:0]        en_o,
   output logic [PRIO_W-1:0]      thr_o,
   output logic                   req_o,
   output logic [IDW-1:0]         id_o,
   output logic [DW-1:0]          rdata_o
);
   logic [NSRC-1:0] pend, accept, elig;
   logic            ack;

   assign ack = sel_i && rd_i && (ofs_i == OFS_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o  <= '0;
         thr_o <= '1;
      end else if (sel_i && wr_i) begin
         case (ofs_i)
            OFS_ENSET: en_o  <= en_o | wdata_i[NSRC-1:0];
            OFS_ENCLR: en_o  <= en_o & ~wdata_i[NSRC-1:0];
            OFS_THR:   thr_o <= wdata_i[PRIO_W-1:0];
            default:   ;
         endcase
      end
   end

   irqc_capture #(.NSRC(NSRC)) i_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (lvl_i),
      .rise_i   (rise_i),
      .sticky_i (sticky_i),
      .ack_i    (ack),
      .pend_o   (pend)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_thr
      assign accept[i] = prio_i[i*PRIO_W +: PRIO_W] <= thr_o;
   end

   assign elig = pend & en_o & accept;

   irqc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) i_arbiter (
      .elig_i  (elig),
      .prio_i  (prio_i),
      .valid_o (req_o),
      .id_o    (id_o)
   );

   always_comb begin
      case (ofs_i)
         OFS_STATUS: rdata_o = DW'(elig);
         OFS_RAW:    rdata_o = DW'(pend);
         OFS_ENSET:  rdata_o = DW'(en_o);
         OFS_CUR:    rdata_o = DW'(id_o);
         OFS_THR:    rdata_o = DW'(thr_o);
         default:    rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/irqc_dual_bank.sv
module irqc_dual_bank
   import irqc_pkg::*;
#(
   parameter int NSRC        = 32,
   parameter int PRIO_W      = 4,
   parameter int DW          = 32,
   parameter int AW          = 10,
   parameter int SYNC_STAGES = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NSRC-1:0]         src_i,
   input  logic                    bus_wr_i,
   input  logic                    bus_rd_i,
   input  logic [AW-1:0]           bus_addr_i,
   input  logic [DW-1:0]           bus_wdata_i,
   output logic [DW-1:0]           bus_rdata_o,
   output logic                    irq_o,
   output logic [$clog2(NSRC)-1:0] irq_id_o,
   output logic                    fiq_o,
   output logic [$clog2(NSRC)-1:0] fiq_id_o
);
   localparam int IDW   = $clog2(NSRC);
   localparam int NBANK = 2;

   if (NSRC < 2 || NSRC > DW || NSRC > 64) begin : g_bad_nsrc
      $error("NSRC must lie in 2..min(DW,64)");
   end
   if (AW != 10) begin : g_bad_aw
      $error("AW must be 10");
   end
   if (PRIO_W < 1 || PRIO_W > DW) begin : g_bad_prio
      $error("PRIO_W out of range");
   end

   logic [1:0]             region;
   logic [7:0]             ofs;
   logic [NSRC-1:0]        src_s, lvl, lvl_q, rise;
   logic [NSRC-1:0]        inv_q, sticky_q;
   logic [PRIO_W-1:0]      prio_q [NSRC];
   logic [NSRC*PRIO_W-1:0] prio_flat;
   logic [NSRC-1:0]        bank_en  [NBANK];
   logic [PRIO_W-1:0]      bank_thr [NBANK];
   logic                   bank_req [NBANK];
   logic [IDW-1:0]         bank_id  [NBANK];
   logic [DW-1:0]          bank_rd  [NBANK];
   logic [DW-1:0]          rd_mux;

   assign region = bus_addr_i[9:8];
   assign ofs    = bus_addr_i[7:0];

   // optional input synchroniser
   if (SYNC_STAGES == 0) begin : g_nosync
      assign src_s = src_i;
   end else begin : g_sync
      logic [NSRC-1:0] sync_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
         end else begin
            sync_q[0] <= src_i;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
         end
      end
      assign src_s = sync_q[SYNC_STAGES-1];
   end

   // a set invert-select bit passes the input unchanged
   assign lvl  = src_s ^ ~inv_q;
   assign rise = lvl & ~lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q    <= '0;
         inv_q    <= '1;
         sticky_q <= '0;
      end else begin
         lvl_q <= lvl;
         if (bus_wr_i && region == RGN_GLB && ofs == OFS_INVERT) inv_q    <= bus_wdata_i[NSRC-1:0];
         if (bus_wr_i && region == RGN_GLB && ofs == OFS_STICKY) sticky_q <= bus_wdata_i[NSRC-1:0];
      end
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prio_q[i] <= '0;
         else if (bus_wr_i && region == RGN_PRIO && ofs[7:2] == 6'(i))
            prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
      end
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      irqc_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .DW(DW)) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel_i    (region == 2'(b)),
         .wr_i     (bus_wr_i),
         .rd_i     (bus_rd_i),
         .ofs_i    (ofs),
         .wdata_i  (bus_wdata_i),
         .lvl_i    (lvl),
         .rise_i   (rise),
         .sticky_i (sticky_q),
         .prio_i   (prio_flat),
         .en_o     (bank_en[b]),
         .thr_o    (bank_thr[b]),
         .req_o    (bank_req[b]),
         .id_o     (bank_id[b]),
         .rdata_o  (bank_rd[b])
      );
   end

   assign irq_o    = bank_req[0];
   assign irq_id_o = bank_id[0];
   assign fiq_o    = bank_req[1];
   assign fiq_id_o = bank_id[1];

   always_comb begin
      rd_mux = '0;
      case (region)
         RGN_IRQ: rd_mux = bank_rd[0];
         RGN_FIQ: rd_mux = bank_rd[1];
         RGN_GLB: begin
            if (ofs == OFS_INVERT) rd_mux = DW'(inv_q);
            if (ofs == OFS_STICKY) rd_mux = DW'(sticky_q);
         end
         default: begin
            for (int i = 0; i < NSRC; i++)
               if (ofs[7:2] == 6'(i)) rd_mux = DW'(prio_q[i]);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bus_rdata_o <= '0;
      else if (bus_rd_i) bus_rdata_o <= rd_mux;
   end
endmodule

// File: rtl/irqc_dual_bank_chk.sv
module irqc_dual_bank_chk #(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 4,
   parameter int DW     = 32,
   parameter int AW     = 10,
   localparam int IDW   = $clog2(NSRC)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   irq_o,
   input logic [IDW-1:0]         irq_id_o,
   input logic                   fiq_o,
   input logic [IDW-1:0]         fiq_id_o,
   input logic [NSRC-1:0]        en_irq,
   input logic [NSRC-1:0]        en_fiq,
   input logic [PRIO_W-1:0]      thr_irq,
   input logic [PRIO_W-1:0]      thr_fiq,
   input logic [NSRC*PRIO_W-1:0] prio_flat,
   input logic                   bus_wr_i,
   input logic [AW-1:0]          bus_addr_i,
   input logic [DW-1:0]          bus_wdata_i
);
   logic seen_clk;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) seen_clk <= 1'b0;
      else        seen_clk <= 1'b1;

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_clk |-> (!irq_o && !fiq_o));

   // R7
   irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> en_irq[irq_id_o]);

   // R9
   fiq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> en_fiq[fiq_id_o]);

   // R7
   irq_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (prio_flat[irq_id_o*PRIO_W +: PRIO_W] <= thr_irq));

   // R7
   fiq_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> (prio_flat[fiq_id_o*PRIO_W +: PRIO_W] <= thr_fiq));

   // R2
   enset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == AW'(10'h008)) |=>
         ((en_irq & $past(bus_wdata_i[NSRC-1:0])) == $past(bus_wdata_i[NSRC-1:0])));

   // R2
   enclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == AW'(10'h00C)) |=>
         ((en_irq & $past(bus_wdata_i[NSRC-1:0])) == '0));
endmodule

bind irqc_dual_bank irqc_dual_bank_chk #(
   .NSRC(NSRC), .PRIO_W(PRIO_W), .DW(DW), .AW(AW)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_o       (irq_o),
   .irq_id_o    (irq_id_o),
   .fiq_o       (fiq_o),
   .fiq_id_o    (fiq_id_o),
   .en_irq      (bank_en[0]),
   .en_fiq      (bank_en[1]),
   .thr_irq     (bank_thr[0]),
   .thr_fiq     (bank_thr[1]),
   .prio_flat   (prio_flat),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i)
);

// File: tb/test_irqc_dual_bank.sv
module test_irqc_dual_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, fiq;
   logic [4:0]  irq_id, fiq_id;

   int n_tests = 0;
   int n_fail  = 0;

   logic [3:0]  m_prio [32];

   irqc_dual_bank i_irqc_dual_bank (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .irq_id_o(irq_id), .fiq_o(fiq), .fiq_id_o(fiq_id)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [9:0] a, logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic set_prio(int i, logic [3:0] p);
      bus_wr(10'h300 + 10'(4*i), {28'd0, p});
      m_prio[i] = p;
   endtask

   // returns {found, id}: lowest priority value, ties to lowest index
   function automatic logic [5:0] pick(logic [31:0] en, logic [3:0] thr, logic [31:0] pend);
      logic found = 1'b0;
      logic [4:0] id = '0;
      for (int i = 0; i < 32; i++) begin
         if (pend[i] && en[i] && m_prio[i] <= thr)
            if (!found || m_prio[i] < m_prio[id]) begin
               found = 1'b1; id = 5'(i);
            end
      end
      return {found, id};
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [5:0]  e;
      for (int i = 0; i < 32; i++) m_prio[i] = '0;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 fiq", {31'd0, fiq}, 0);
      bus_rd(10'h008, d); chk("R1 irq enable", d, 0);
      bus_rd(10'h108, d); chk("R1 fiq enable", d, 0);
      bus_rd(10'h02C, d); chk("R1 irq thr", d, 32'hF);
      bus_rd(10'h12C, d); chk("R1 fiq thr", d, 32'hF);
      bus_rd(10'h200, d); chk("R1 invert", d, 32'hFFFF_FFFF);
      bus_rd(10'h204, d); chk("R1 sticky", d, 0);
      bus_rd(10'h314, d); chk("R1 prio5", d, 0);

      // R2 enable set / clear
      bus_wr(10'h008, 32'h0000_00A5);
      bus_rd(10'h008, d); chk("R2 set", d, 32'hA5);
      bus_wr(10'h00C, 32'h0000_0005);
      bus_rd(10'h008, d); chk("R2 clear", d, 32'hA0);
      bus_wr(10'h008, 32'h0000_0100);
      bus_rd(10'h008, d); chk("R2 set again", d, 32'h1A0);
      bus_rd(10'h108, d); chk("R2 other bank untouched", d, 0);
      bus_wr(10'h00C, 32'hFFFF_FFFF);

      // R3 level source follows input in the same cycle
      bus_wr(10'h008, 32'h0000_0008);
      @(negedge clk); src = 32'h8; #1;
      chk("R3 irq up", {31'd0, irq}, 1);
      chk("R3 id", {27'd0, irq_id}, 3);
      @(negedge clk); src = 0; #1;
      chk("R3 irq down", {31'd0, irq}, 0);
      bus_wr(10'h00C, 32'hFFFF_FFFF);

      // R4 inverted source active low
      bus_wr(10'h200, ~32'h10);
      bus_wr(10'h008, 32'h10);
      #1;
      chk("R4 inverted active at low", {26'd0, irq, irq_id}, {26'd0, 1'b1, 5'd4});
      @(negedge clk); src = 32'h10; #1;
      chk("R4 inverted idle at high", {31'd0, irq}, 0);
      @(negedge clk); src = 0;
      bus_wr(10'h200, 32'hFFFF_FFFF);
      bus_wr(10'h00C, 32'hFFFF_FFFF);

      // R5 sticky latch and per-bank acknowledge
      bus_wr(10'h204, 32'h40);
      bus_wr(10'h008, 32'h40);
      bus_wr(10'h108, 32'h40);
      @(negedge clk); src = 32'h40; #1;
      chk("R5 not before edge", {31'd0, irq}, 0);
      @(negedge clk); src = 0; #1;
      chk("R5 irq latched", {26'd0, irq, irq_id}, {26'd0, 1'b1, 5'd6});
      chk("R5 fiq latched", {26'd0, fiq, fiq_id}, {26'd0, 1'b1, 5'd6});
      bus_rd(10'h004, d); chk("R8 raw sticky", d, 32'h40);
      bus_rd(10'h128, d); #1;
      chk("R5 fiq cleared by own ack", {31'd0, fiq}, 0);
      chk("R5 irq kept on other ack", {31'd0, irq}, 1);
      bus_rd(10'h028, d); #1;
      chk("R5 irq cleared", {31'd0, irq}, 0);
      bus_wr(10'h204, 0);
      bus_wr(10'h00C, 32'hFFFF_FFFF);
      bus_wr(10'h10C, 32'hFFFF_FFFF);

      // R6 priority and tie
      set_prio(10, 4'd5); set_prio(12, 4'd2); set_prio(20, 4'd2);
      bus_wr(10'h008, 32'h0010_1400);
      @(negedge clk); src = 32'h0010_1400; #1;
      chk("R6 winner id", {27'd0, irq_id}, 12);
      bus_rd(10'h020, d); chk("R6 current reg", d, 12);
      @(negedge clk); src = 32'h0010_0400; #1;
      chk("R6 next", {27'd0, irq_id}, 20);
      @(negedge clk); src = 32'h0000_0400; #1;
      chk("R6 last", {27'd0, irq_id}, 10);

      // R7 / R8 threshold
      @(negedge clk); src = 32'h0010_0400;
      bus_wr(10'h02C, 32'h1); #1;
      chk("R7 all above thr", {31'd0, irq}, 0);
      bus_rd(10'h000, d); chk("R8 status zero", d, 0);
      bus_rd(10'h004, d); chk("R8 raw pending", d, 32'h0010_0400);
      bus_rd(10'h020, d); chk("R6 current none", d, 0);
      bus_wr(10'h02C, 32'h2); #1;
      chk("R7 at thr accepted", {26'd0, irq, irq_id}, {26'd0, 1'b1, 5'd20});
      bus_rd(10'h000, d); chk("R8 status bitmap", d, 32'h0010_0000);

      // R9 both banks, own thresholds
      bus_wr(10'h108, 32'h0010_0400);
      bus_wr(10'h12C, 32'hF);
      bus_wr(10'h02C, 32'h1); #1;
      chk("R9 irq gated", {31'd0, irq}, 0);
      chk("R9 fiq reports", {26'd0, fiq, fiq_id}, {26'd0, 1'b1, 5'd20});

      // random phase, level sources only
      for (int it = 0; it < 60; it++) begin
         logic [31:0] en_i, en_f, s;
         logic [3:0]  t_i, t_f;
         for (int k = 0; k < 4; k++) set_prio($urandom_range(31), 4'($urandom_range(15)));
         en_i = $urandom; en_f = $urandom;
         t_i = 4'($urandom); t_f = 4'($urandom);
         bus_wr(10'h00C, 32'hFFFF_FFFF); bus_wr(10'h008, en_i); bus_wr(10'h02C, {28'd0, t_i});
         bus_wr(10'h10C, 32'hFFFF_FFFF); bus_wr(10'h108, en_f); bus_wr(10'h12C, {28'd0, t_f});
         s = $urandom & $urandom;
         if (it % 5 == 0) s = 0;
         @(negedge clk); src = s; #1;
         e = pick(en_i, t_i, s);
         chk("R6 rand irq", {26'd0, irq, irq ? irq_id : 5'd0}, {26'd0, e});
         e = pick(en_f, t_f, s);
         chk("R9 rand fiq", {26'd0, fiq, fiq ? fiq_id : 5'd0}, {26'd0, e});
         bus_rd(10'h020, d);
         e = pick(en_i, t_i, s);
         chk("R6 rand current", d, {27'd0, e[4:0]});
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule